// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines and presents one of them at a time to a processor core as a request strobe plus a source index. Every source belongs to one of six groups. Software gives each group one of four priority levels, and all members of a group share that level. A request pulse latches into a per-source pending flag. The arbiter then picks the best pending source that is enabled both individually and globally. It orders candidates first by level, then by group number, then by source number.

The block tracks nested handlers on a small stack of in-service levels. While a handler runs, only a request with a strictly higher level is presented. A return-from-interrupt pops the stack, which lets waiting lower-level work through again. A fixed set of wake-capable sources covers the port-pin and sleep-timer lines. When one of them is pending and enabled while the core sleeps, the block raises a wake line so that the system can return to active mode.

Software reaches the block through a small write port. Address 0 holds the per-source enables. Bit 0 of address 1 is the global enable. Address 2 holds the group priority fields. Writing ones to address 3 clears the matching pending flags.

Top module: `gpic_top`

## Requirements
- R1: A one-cycle high on bit s of `req_i` sets pending flag s at that clock edge, and the flag stays set until it is cleared by R5 or R6, whether or not the source is enabled.
- R2: Source s belongs to group s mod 6. The level of group g is written at bits [2g+1:2g] of address 2. Value 3 is the highest level and 0 the lowest.
- R3: `irq_o` rises at the second rising edge after a request is latched, and `vec_o` then holds the index of the winning source. The winner is the highest-level candidate. Ties go to the lower group number, and ties within a group go to the lower source number.
- R4: A source is a candidate only if its bit in address 0 is 1 and bit 0 of address 1 is 1. A disabled source is never presented, but its pending flag is kept and it is presented once it is enabled.
- R5: Writing a 1 to bit s of address 3 clears pending flag s. If a request for s arrives in the same cycle, the request wins and the flag stays set.
- R6: An `ack_i` sampled while `irq_o` is high clears the pending flag of `vec_o` and pushes its level onto the in-service stack. `irq_o` is low in the cycle after the acknowledge.
- R7: While the in-service stack is not empty, a source is presented only if its level is strictly greater than the level on top of the stack.
- R8: A `reti_i` pulse pops the in-service stack. Pending sources that the old top blocked are then presented again.
- R9: The in-service stack holds at most 4 levels, and its depth never exceeds that.
- R10: `wake_o` is high one cycle after `sleep_i` is high while a wake-capable source is a candidate. The wake-capable sources are 0 to 7 and 17. Other sources never raise `wake_o`.
- R11: After reset all enables, priorities, pending flags and the stack are cleared, and `irq_o`, `vec_o` and `wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 18 | Request pulses, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 source enables, 1 global enable, 2 group levels, 3 flag clear |
| wr_data_i | input | 18 | Register write data |
| ack_i | input | 1 | Processor takes the presented interrupt |
| reti_i | input | 1 | Processor leaves the current handler |
| sleep_i | input | 1 | Core is in a sleep mode |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 5 | Index of the presented source |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
The checker assumes that the processor acknowledges only while `irq_o` is high. It also assumes that the processor never acknowledges and returns in the same cycle, and that it issues a return only for a handler it actually entered. Under these assumptions the stack depth bound and the strict-preemption rule follow from the inputs. The stimulus keeps to these rules through a single service task: it waits for `irq_o`, checks the presented index against the scoreboard queue, and only then pulses `ack_i`. Returns are issued once per acknowledged handler, in a separate cycle.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  // Priority levels and the width of one group priority field.
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);

  // Register select on the write port.
  typedef enum logic [1:0] {
    SEL_SRC_EN   = 2'd0,
    SEL_GLB_EN   = 2'd1,
    SEL_GRP_PRI  = 2'd2,
    SEL_FLAG_CLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
  import gpic_pkg::*;
#(
  parameter int unsigned N_SRC = 18,
  parameter int unsigned N_GRP = 6,
  parameter int unsigned WR_W  = 18,
  localparam int unsigned PRI_W = N_GRP * LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] ack_clr,
  output logic [N_SRC-1:0] src_en,
  output logic             glb_en,
  output logic [PRI_W-1:0] grp_pri,
  output logic [N_SRC-1:0] pending
);
  reg_sel_e         sel;
  logic [N_SRC-1:0] flag_clr;

  assign sel      = reg_sel_e'(wr_addr);
  assign flag_clr = (wr_en && sel == SEL_FLAG_CLR) ? wr_data[N_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en  <= '0;
      glb_en  <= 1'b0;
      grp_pri <= '0;
      pending <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_SRC_EN:  src_en  <= wr_data[N_SRC-1:0];
          SEL_GLB_EN:  glb_en  <= wr_data[0];
          SEL_GRP_PRI: grp_pri <= wr_data[PRI_W-1:0];
          default: ;
        endcase
      end
      // New requests take precedence over any clear in the same cycle.
      pending <= (pending & ~(flag_clr | ack_clr)) | req;
    end
  end
endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
  import gpic_pkg::*;
#(
  parameter int unsigned N_SRC = 18,
  parameter int unsigned N_GRP = 6,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned MEMB  = (N_SRC + N_GRP - 1) / N_GRP
) (
  input  logic [N_SRC-1:0]       cand,
  input  logic [N_GRP*LVL_W-1:0] grp_pri,
  output logic                   hit,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_lvl
);
  // Level of every source, taken from the field of its group.
  logic [LVL_W-1:0] src_lvl [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
    localparam int unsigned GRP = s % N_GRP;
    assign src_lvl[s] = grp_pri[GRP*LVL_W +: LVL_W];
  end

  // Scan order: level high to low, group low to high, member low to high.
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      for (int g = 0; g < N_GRP; g++) begin
        for (int m = 0; m < MEMB; m++) begin
          if ((g + m * N_GRP) < N_SRC) begin
            if (!hit && cand[g + m * N_GRP] &&
                src_lvl[g + m * N_GRP] == LVL_W'(l)) begin
              hit     = 1'b1;
              win_idx = IDX_W'(g + m * N_GRP);
              win_lvl = LVL_W'(l);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/gpic_stack.sv
module gpic_stack
  import gpic_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [CNT_W-1:0] depth,
  output logic [LVL_W-1:0] top_lvl
);
  logic [LVL_W-1:0] lvl_mem [DEPTH];
  logic [CNT_W-1:0] top_ptr;

  assign top_ptr = depth - CNT_W'(1);
  assign top_lvl = (depth == '0) ? '0 : lvl_mem[top_ptr[PTR_W-1:0]];

  // Storage has no reset; only entries below the depth are ever read.
  always_ff @(posedge clk) begin
    if (push && depth < CNT_W'(DEPTH)) begin
      lvl_mem[depth[PTR_W-1:0]] <= push_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
    end else if (push && depth < CNT_W'(DEPTH)) begin
      depth <= depth + CNT_W'(1);
    end else if (pop && depth != '0) begin
      depth <= depth - CNT_W'(1);
    end
  end
endmodule

// File: rtl/gpic_top.sv
module gpic_top
  import gpic_pkg::*;
#(
  parameter int unsigned      N_SRC       = 18,
  parameter int unsigned      N_GRP       = 6,
  parameter int unsigned      STACK_DEPTH = 4,
  parameter logic [N_SRC-1:0] WAKE_MASK   = 18'h200FF,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned PRI_W = N_GRP * LVL_W,
  localparam int unsigned WR_W  = (N_SRC > PRI_W) ? N_SRC : PRI_W,
  localparam int unsigned CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [WR_W-1:0]  wr_data_i,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic             sleep_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] vec_o,
  output logic             wake_o
);
  logic [N_SRC-1:0] src_en_w, pending_w, cand_w, ack_clr_w;
  logic             glb_en_w;
  logic [PRI_W-1:0] grp_pri_w;
  logic             hit_w, allow_w, take_w;
  logic [IDX_W-1:0] win_idx_w;
  logic [LVL_W-1:0] win_lvl_w, top_lvl_w;
  logic [CNT_W-1:0] depth_w;

  logic             irq_q, wake_q;
  logic [IDX_W-1:0] vec_q;
  logic [LVL_W-1:0] lvl_q;

  assign take_w = ack_i && irq_q;
  assign cand_w = pending_w & src_en_w & {N_SRC{glb_en_w}};

  for (genvar s = 0; s < N_SRC; s++) begin : g_ack
    assign ack_clr_w[s] = take_w && (vec_q == IDX_W'(s));
  end

  gpic_regs #(.N_SRC(N_SRC), .N_GRP(N_GRP), .WR_W(WR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .req     (req_i),
    .ack_clr (ack_clr_w),
    .src_en  (src_en_w),
    .glb_en  (glb_en_w),
    .grp_pri (grp_pri_w),
    .pending (pending_w)
  );

  gpic_arbiter #(.N_SRC(N_SRC), .N_GRP(N_GRP)) u_arb (
    .cand    (cand_w),
    .grp_pri (grp_pri_w),
    .hit     (hit_w),
    .win_idx (win_idx_w),
    .win_lvl (win_lvl_w)
  );

  gpic_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (take_w),
    .push_lvl (lvl_q),
    .pop      (reti_i),
    .depth    (depth_w),
    .top_lvl  (top_lvl_w)
  );

  // Preemption needs a strictly higher level than the handler in service.
  assign allow_w = hit_w && (depth_w == '0 || win_lvl_w > top_lvl_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      lvl_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= allow_w && !take_w;
      if (allow_w) begin
        vec_q <= win_idx_w;
        lvl_q <= win_lvl_w;
      end
      wake_q <= sleep_i && |(cand_w & WAKE_MASK);
    end
  end

  assign irq_o  = irq_q;
  assign vec_o  = vec_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/gpic_checker.sv
module gpic_checker #(
  parameter int unsigned N_SRC       = 18,
  parameter int unsigned STACK_DEPTH = 4,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned LVL_W       = 2,
  parameter int unsigned CNT_W       = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_i,
  input logic             sleep_i,
  input logic             irq_o,
  input logic [IDX_W-1:0] vec_o,
  input logic             wake_o,
  input logic             glb_en,
  input logic [CNT_W-1:0] depth,
  input logic [LVL_W-1:0] irq_lvl,
  input logic [LVL_W-1:0] top_lvl
);
  assert_vec_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_o < IDX_W'(N_SRC)));

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(glb_en));

  assert_drop_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o) |=> !irq_o);

  assert_strict_preempt_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && depth != '0) |-> (irq_lvl > top_lvl));

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(STACK_DEPTH));

  assert_wake_needs_sleep_R10: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(sleep_i));
endmodule

bind gpic_top gpic_checker #(
  .N_SRC(N_SRC), .STACK_DEPTH(STACK_DEPTH), .IDX_W(IDX_W),
  .LVL_W(gpic_pkg::LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ack_i   (ack_i),
  .sleep_i (sleep_i),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .wake_o  (wake_o),
  .glb_en  (glb_en_w),
  .depth   (depth_w),
  .irq_lvl (lvl_q),
  .top_lvl (top_lvl_w)
);

// File: tb/gpic_top_tb.sv
module gpic_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] req_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [17:0] wr_data_i = '0;
  logic        ack_i = 1'b0;
  logic        reti_i = 1'b0;
  logic        sleep_i = 1'b0;
  logic        irq_o;
  logic [4:0]  vec_o;
  logic        wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  gpic_top u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
    .reti_i(reti_i), .sleep_i(sleep_i), .irq_o(irq_o), .vec_o(vec_o),
    .wake_o(wake_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [17:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [17:0] m);
    @(negedge clk);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic reti();
    @(negedge clk);
    reti_i = 1'b1;
    @(negedge clk);
    reti_i = 1'b0;
  endtask

  // Driver side of the scoreboard.
  task automatic expect_vec(input int v);
    exp_q.push_back(v);
  endtask

  // Monitor side: wait for a request, compare it with the queue, acknowledge.
  task automatic serve(input string tag);
    int exp;
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (irq_o) seen = 1'b1;
    end
    exp = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
    check({tag, " irq seen"}, int'(seen), 1);
    if (seen) begin
      check({tag, " vector"}, int'(vec_o), exp);
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      check("R6 irq low after ack", int'(irq_o), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    settle(4);
    rst = 1'b0;
    settle(1);
    // R11 reset state
    check("R11 irq after reset", int'(irq_o), 0);
    check("R11 vec after reset", int'(vec_o), 0);
    check("R11 wake after reset", int'(wake_o), 0);

    // R4 global enable gates; R1 pending held meanwhile
    wr(2'd0, 18'h3FFFF);
    pulse(18'h1 << 9);
    settle(3);
    check("R4 global disable blocks", int'(irq_o), 0);
    wr(2'd1, 18'h1);
    expect_vec(9);
    serve("R1 latched request");
    settle(3);
    check("R6 pending cleared by ack", int'(irq_o), 0);
    reti();

    // R4 individual enable: flag kept while disabled
    wr(2'd0, 18'h3FFFF & ~(18'h1 << 10));
    pulse(18'h1 << 10);
    settle(3);
    check("R4 source disable blocks", int'(irq_o), 0);
    wr(2'd0, 18'h3FFFF);
    expect_vec(10);
    serve("R4 kept flag");
    reti();

    // R5 flag clear removes a pending request
    wr(2'd0, 18'h3FFFF & ~(18'h1 << 5));
    pulse(18'h1 << 5);
    wr(2'd3, 18'h1 << 5);
    wr(2'd0, 18'h3FFFF);
    settle(3);
    check("R5 cleared flag not presented", int'(irq_o), 0);

    // R5 request wins over clear in the same cycle
    @(negedge clk);
    req_i = 18'h1 << 11; wr_en_i = 1'b1; wr_addr_i = 2'd3; wr_data_i = 18'h1 << 11;
    @(negedge clk);
    req_i = '0; wr_en_i = 1'b0;
    expect_vec(11);
    serve("R5 set beats clear");
    reti();

    // R2/R3 levels: group2=1, group4=3, others 0; R7 blocking; R8 pop
    wr(2'd2, 18'h310);
    pulse((18'h1 << 2) | (18'h1 << 4));
    expect_vec(4);
    serve("R3 higher level first");
    settle(3);
    check("R7 lower level blocked", int'(irq_o), 0);
    reti();
    expect_vec(2);
    serve("R8 presented after pop");
    reti();
    pulse((18'h1 << 3) | (18'h1 << 16));
    expect_vec(16);
    serve("R2 source 16 in group 4");
    reti();
    expect_vec(3);
    serve("R2 source 3 level 0");
    reti();

    // R3 ties at equal level: lower group, then lower member
    wr(2'd2, 18'h0);
    pulse((18'h1 << 8) | (18'h1 << 13));
    expect_vec(13);
    serve("R3 lower group wins");
    settle(3);
    check("R7 equal level blocked", int'(irq_o), 0);
    reti();
    expect_vec(8);
    serve("R8 equal level after pop");
    reti();
    pulse((18'h1 << 13) | (18'h1 << 7));
    expect_vec(7);
    serve("R3 lower member wins");
    reti();
    expect_vec(13);
    serve("R3 second member");
    reti();

    // R9 full nesting: group g level g for g=0..3
    wr(2'd2, 18'h0E4);
    for (int k = 0; k < 4; k++) begin
      pulse(18'h1 << k);
      expect_vec(k);
      serve("R9 nest step");
    end
    pulse(18'h1 << 9);
    settle(3);
    check("R9 top level no preempt at full stack", int'(irq_o), 0);
    reti();
    expect_vec(9);
    serve("R8 level 3 after pop");
    for (int k = 0; k < 4; k++) reti();
    settle(3);
    check("R8 stack drained no request", int'(irq_o), 0);

    // R10 wake
    sleep_i = 1'b1;
    pulse(18'h1 << 12);
    settle(3);
    check("R10 non-wake source", int'(wake_o), 0);
    pulse(18'h1 << 17);
    settle(3);
    check("R10 wake source while asleep", int'(wake_o), 1);
    sleep_i = 1'b0;
    settle(2);
    check("R10 wake drops when awake", int'(wake_o), 0);
    wr(2'd3, 18'h3FFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule